// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and presents a single interrupt request to the processor. Each source has a 4-bit priority and an enable bit. Software sets or clears one enable bit per write by writing the source number to a dedicated register, so no read-modify-write is needed. A mask level register blocks every source whose priority does not exceed it. This lets a handler shut out lower levels while it services a request.

A vector status register gives the winning source in one read. The winner is the eligible source with the highest priority, and the lowest number wins a tie. The register returns the source number in the upper half and the priority in the lower half. It reads as all ones, which is negative as a signed word, when no source is eligible. Register reads are combinational from the word address, and writes take effect on the next rising clock edge.

Register map (word addresses): 0 mask level (bits [3:0]), 1 enable-by-number, 2 disable-by-number, 3 enable readback for sources 0..31, 4 enable readback for sources 32..63, 5 vector status, 8..15 priority registers.

Top module: `vic_top`

## Requirements
- R1: After a synchronous active-low reset, all enable bits, priority fields and the mask level are zero. The vector status reads 0xFFFFFFFF and `cpu_irq_o` is low.
- R2: A write to address 1 sets the enable bit of the source given by `reg_wdata_i[5:0]` and leaves every other enable bit unchanged.
- R3: A write to address 2 clears the enable bit of the source given by `reg_wdata_i[5:0]` and leaves every other enable bit unchanged.
- R4: The priority of source s sits in bits [4*(s%8)+3 : 4*(s%8)] of the priority register at word address 15 - s/8. Sources 0..7 are therefore at address 15 and sources 56..63 at address 8. Each priority register reads back as written.
- R5: The mask level is written through bits [3:0] at address 0. It reads back in bits [3:0] with the upper bits zero, and it changes only when address 0 is written.
- R6: A source is eligible only when its request line is high, its enable bit is set, and its priority is strictly greater than the mask level.
- R7: Among the eligible sources the one with the highest priority wins, and on equal priority the lower-numbered source wins.
- R8: While a source is eligible, a read of address 5 returns the winner's number in bits [31:16] and its priority in bits [15:0], with all other bits zero.
- R9: While no source is eligible, a read of address 5 returns 0xFFFFFFFF.
- R10: `cpu_irq_o` is high exactly while some source is eligible. It follows the request lines with no latching, so dropping the line removes the request.
- R11: Address 3 returns the enable bits of sources 0..31 and address 4 returns those of sources 32..63, with source 32 in bit 0 of the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_lines_i | input | 64 | Level-sensitive interrupt request lines |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
Directed cases exercise several features one at a time:
- Enable bits at both word boundaries (sources 0, 31, 32 and 63).
- Equal priorities on two far-apart sources, which shows that the tie goes to the lower number.
- A mask equal to the top priority against a mask one below it, which separates the strict comparison from an inclusive one.
- Dropping a request line, which shows that requests are level-sensitive.

Randomized sequences mix single-source enable and disable writes, whole priority-register writes, mask writes and new request patterns. After every step the vector status, the interrupt output and both enable words are compared against a reference model, which catches wrong field placement and wrong register order in the priority map.

// File: rtl/vic_pkg.sv
// Package: shared constants, register addresses and the arbitration
// candidate type of the vectored interrupt controller.
// Assumes SRC_N is a power of two and DATA_W is a multiple of PRIO_W.
package vic_pkg;

    localparam int SRC_N     = 64;
    localparam int SRC_W     = $clog2(SRC_N);
    localparam int PRIO_W    = 4;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int PER_REG   = DATA_W / PRIO_W;
    localparam int PRIO_REGS = SRC_N / PER_REG;
    localparam int PSEL_W    = $clog2(PRIO_REGS);
    localparam int HALF_W    = DATA_W / 2;

    localparam logic [ADDR_W-1:0] A_MASK     = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_EN_LO    = 4'd3;
    localparam logic [ADDR_W-1:0] A_EN_HI    = 4'd4;
    localparam logic [ADDR_W-1:0] A_VEC      = 4'd5;
    localparam logic [ADDR_W-1:0] A_PRIO_TOP = 4'd15;
    localparam logic [ADDR_W-1:0] A_PRIO_BOT = A_PRIO_TOP - ADDR_W'(PRIO_REGS - 1);

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  idx;
    } cand_t;

endpackage

// File: rtl/vic_enable_bank.sv
// Module: per-source enable bits, set or cleared one source at a time.
// Assumes set_stb and clr_stb are never high together (distinct addresses).
module vic_enable_bank
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [SRC_W-1:0] sel,
    output logic [SRC_N-1:0] en
);

    // Update only the selected enable bit on a set or clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else begin
            if (set_stb) en[sel] <= 1'b1;
            if (clr_stb) en[sel] <= 1'b0;
        end
    end

    // R2: a set strobe leaves the selected source enabled.
    assert_set_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> en[$past(sel)]);

    // R3: a clear strobe leaves the selected source disabled.
    assert_clr_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !en[$past(sel)]);

    // R2, R3: with no strobe no enable bit moves.
    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(en));

    // R3: a single strobe changes at most one bit.
    assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> $countones(en ^ $past(en)) <= 1);

endmodule

// File: rtl/vic_prio_bank.sv
// Module: priority storage, PER_REG fields per word, words placed at
// descending addresses from A_PRIO_TOP. Provides the field of every
// source and the addressed word for readback.
module vic_prio_bank
    import vic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          hit,
    output logic [DATA_W-1:0]             rd_word,
    output logic [SRC_N-1:0][PRIO_W-1:0]  prio
);

    logic [DATA_W-1:0] words [PRIO_REGS];
    logic [PSEL_W-1:0] wsel;

    // Decode whether the address falls in the priority window and which word.
    always_comb begin
        hit  = (addr >= A_PRIO_BOT) && (addr <= A_PRIO_TOP);
        wsel = PSEL_W'(A_PRIO_TOP - addr);
    end

    // Store a whole priority word on a write inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < PRIO_REGS; k++) words[k] <= '0;
        end else if (wr && hit) begin
            words[wsel] <= wdata;
        end
    end

    assign rd_word = words[wsel];

    // Unpack the field of each source from its word.
    for (genvar s = 0; s < SRC_N; s++) begin : g_field
        assign prio[s] = words[s / PER_REG][PRIO_W*(s % PER_REG) +: PRIO_W];
    end

    // R4: a word not written keeps its content.
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit) |=> $stable(prio));

endmodule

// File: rtl/vic_arbiter.sv
// Module: eligibility filter plus a balanced selection tree that returns
// the highest-priority eligible source; the left (lower-numbered) branch
// wins ties. Purely combinational. Assumes SRC_N is a power of two.
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [SRC_N-1:0]              req,
    input  logic [SRC_N-1:0]              en,
    input  logic [SRC_N-1:0][PRIO_W-1:0]  prio,
    input  logic [PRIO_W-1:0]             mask_lvl,
    output cand_t                         win
);

    logic [SRC_N-1:0] elig;
    cand_t            node [2*SRC_N];

    // Per-source eligibility: requested, enabled and above the mask.
    for (genvar s = 0; s < SRC_N; s++) begin : g_elig
        assign elig[s] = req[s] && en[s] && (prio[s] > mask_lvl);
    end

    // Heap-ordered tree: leaves at SRC_N+s, root at node 1.
    always_comb begin
        for (int i = 0; i < SRC_N; i++) node[i] = '0;
        for (int s = 0; s < SRC_N; s++) begin
            node[SRC_N+s].valid = elig[s];
            node[SRC_N+s].prio  = prio[s];
            node[SRC_N+s].idx   = SRC_W'(s);
        end
        for (int i = SRC_N - 1; i >= 1; i--) begin
            if (node[2*i+1].valid &&
                (!node[2*i].valid || node[2*i+1].prio > node[2*i].prio))
                node[i] = node[2*i+1];
            else
                node[i] = node[2*i];
        end
        win = node[1];
    end

endmodule

// File: rtl/vic_top.sv
// Module: top of the vectored interrupt controller. Holds the mask level,
// decodes register writes, muxes register reads and drives the processor
// request. Assumes a single-cycle write strobe and combinational reads.
module vic_top
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [3:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [63:0]       irq_lines_i,
    output logic              cpu_irq_o
);

    logic [PRIO_W-1:0]             mask_q;
    logic [SRC_N-1:0]              en;
    logic [SRC_N-1:0][PRIO_W-1:0]  prio;
    logic                          prio_hit;
    logic [DATA_W-1:0]             prio_word;
    logic                          set_stb, clr_stb;
    cand_t                         win;

    // Decode the single-source enable strobes.
    always_comb begin
        set_stb = reg_wr_i && (reg_addr_i == A_EN_SET);
        clr_stb = reg_wr_i && (reg_addr_i == A_EN_CLR);
    end

    // Mask level register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr_i && reg_addr_i == A_MASK)
            mask_q <= reg_wdata_i[PRIO_W-1:0];
    end

    vic_enable_bank u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .sel     (reg_wdata_i[SRC_W-1:0]),
        .en      (en)
    );

    vic_prio_bank u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .hit     (prio_hit),
        .rd_word (prio_word),
        .prio    (prio)
    );

    vic_arbiter u_arb (
        .req      (irq_lines_i),
        .en       (en),
        .prio     (prio),
        .mask_lvl (mask_q),
        .win      (win)
    );

    assign cpu_irq_o = win.valid;

    // Register read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_MASK:  reg_rdata_o = DATA_W'(mask_q);
            A_EN_LO: reg_rdata_o = en[DATA_W-1:0];
            A_EN_HI: reg_rdata_o = en[2*DATA_W-1:DATA_W];
            A_VEC:   reg_rdata_o = win.valid
                                 ? {HALF_W'(win.idx), HALF_W'(win.prio)}
                                 : '1;
            default: if (prio_hit) reg_rdata_o = prio_word;
        endcase
    end

    // R5: the mask level moves only on a write to its address.
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == A_MASK) |=> $stable(mask_q));

    // R6: a reported winner is requested, enabled and above the mask.
    assert_win_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> (irq_lines_i[win.idx] && en[win.idx] && prio[win.idx] > mask_q));

    // R8: the vector status carries the winner number and its own priority.
    assert_vec_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && reg_addr_i == A_VEC) |->
            (reg_rdata_o[31:16] == 16'(win.idx) && reg_rdata_o[15:0] == 16'(prio[win.idx])));

    // R9: with nothing eligible the vector status is all ones.
    assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_o && reg_addr_i == A_VEC) |-> reg_rdata_o == 32'hFFFF_FFFF);

    // R10: with all request lines low the processor request is low.
    assert_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines_i == '0) |-> !cpu_irq_o);

endmodule

// File: tb/vic_top_tb_top.sv
// Bench: directed corner cases plus seeded random register traffic,
// compared against a reference model held in bench variables.
module vic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = 4'd0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [63:0] irq_lines_i = '0;
    logic        cpu_irq_o;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_en = '0;
    logic [3:0]  m_prio [64];
    logic [3:0]  m_mask = '0;

    always #5 clk = ~clk;

    vic_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_lines_i (irq_lines_i),
        .cpu_irq_o   (cpu_irq_o)
    );

    function automatic logic [31:0] exp_vec();
        int best = -1;
        logic [3:0] bp = '0;
        for (int s = 0; s < 64; s++) begin
            if (irq_lines_i[s] && m_en[s] && m_prio[s] > m_mask &&
                (best < 0 || m_prio[s] > bp)) begin
                best = s;
                bp   = m_prio[s];
            end
        end
        if (best < 0) return 32'hFFFF_FFFF;
        return {16'(best), 12'd0, bp};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk);
        #1 reg_wr_i = 1'b0;
        if (a == 4'd0) m_mask = d[3:0];
        else if (a == 4'd1) m_en[d[5:0]] = 1'b1;
        else if (a == 4'd2) m_en[d[5:0]] = 1'b0;
        else if (a >= 4'd8) for (int j = 0; j < 8; j++) m_prio[(15 - a) * 8 + j] = d[4*j +: 4];
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_vec();
        rd(4'd5, d); check({tag, " vec R8/R7"}, d, e);
        check({tag, " irq R10"}, {31'd0, cpu_irq_o}, {31'd0, e != 32'hFFFF_FFFF});
        rd(4'd3, d); check({tag, " en lo R11"}, d, m_en[31:0]);
        rd(4'd4, d); check({tag, " en hi R11"}, d, m_en[63:32]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int s = 0; s < 64; s++) m_prio[s] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        irq_lines_i = '1;
        rd(4'd5, d); check("R1 vec after reset", d, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'd0, cpu_irq_o}, 32'd0);
        rd(4'd0, d); check("R1 mask after reset", d, 32'd0);
        rd(4'd8, d); check("R1 prio after reset", d, 32'd0);
        rd(4'd3, d); check("R1 en lo after reset", d, 32'd0);
        irq_lines_i = '0;

        // R2, R11: enables at word edges
        wr(4'd1, 32'd0); wr(4'd1, 32'd31); wr(4'd1, 32'd32); wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd3, d); check("R2 en lo", d, 32'h8000_0001);
        rd(4'd4, d); check("R11 en hi", d, 32'h8000_0001);
        // R3: clear one only
        wr(4'd2, 32'd32);
        rd(4'd4, d); check("R3 en hi after clear", d, 32'h8000_0000);
        rd(4'd3, d); check("R3 en lo untouched", d, 32'h8000_0001);

        // R4: packing and descending order
        wr(4'd15, 32'h7654_3210);
        rd(4'd15, d); check("R4 readback top", d, 32'h7654_3210);
        rd(4'd8, d);  check("R4 bottom untouched", d, 32'd0);
        // R5: mask readback upper bits zero
        wr(4'd0, 32'hFFFF_FFF2);
        rd(4'd0, d); check("R5 mask readback", d, 32'd2);
        wr(4'd0, 32'd0);

        // R7: tie on priority 3 between sources 5 and 40 -> 5
        wr(4'd1, 32'd5); wr(4'd1, 32'd40);
        wr(4'd15, 32'h0030_0000);            // source 5 prio 3
        wr(4'd10, 32'h0000_0003);            // source 40 prio 3 (address 15-5)
        irq_lines_i = (64'd1 << 5) | (64'd1 << 40);
        rd(4'd5, d); check("R7 tie lower wins", d, {16'd5, 16'd3});
        wr(4'd10, 32'h0000_0009);            // source 40 prio 9
        rd(4'd5, d); check("R7 higher prio wins", d, {16'd40, 16'd9});
        // R6: mask equal to top prio blocks it, one below does not
        wr(4'd0, 32'd9);
        rd(4'd5, d); check("R6 mask equal blocks", d, 32'hFFFF_FFFF);
        check("R9 irq low when masked", {31'd0, cpu_irq_o}, 32'd0);
        wr(4'd0, 32'd8);
        rd(4'd5, d); check("R6 mask below passes", d, {16'd40, 16'd9});
        // R10: level sensitive
        irq_lines_i[40] = 1'b0;
        #1 check("R10 irq drops with line", {31'd0, cpu_irq_o}, 32'd0);
        wr(4'd0, 32'd0);
        check_all("directed");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0, 1: wr(4'd1, $urandom);
                2:    wr(4'd2, $urandom);
                3:    wr(4'(8 + $urandom_range(0, 7)), $urandom);
                4:    wr(4'd0, $urandom_range(0, 15) < 10 ? 32'($urandom_range(0, 5)) : $urandom);
                default: irq_lines_i = {$urandom, $urandom};
            endcase
            check_all("random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule